// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits between a host that wants one AUX channel transaction carried out and the channel engine that actually runs each attempt on the wire. After the host starts a transaction, the controller launches an attempt, waits for the engine to report how it went, and then decides on its own whether to finish with a pass, finish with a fail, or launch again. Retrying may come right away or after a pause of a set number of microseconds or of host-chosen milliseconds.

Each kind of trouble has its own budget. Short reads, native defers, I2C-side busy defers, invalid replies and timeouts are counted separately. A timeout that arrives after any defer is taken as one more defer, not as a plain timeout. The pauses are timed by an external microsecond tick. The final verdict stays on the outputs until the host acknowledges it.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `attemptGo` are all low.
- R2: In idle, a `txnStart` pulse launches the first attempt. Every attempt is a one-cycle `attemptGo` pulse. No more than 7 attempts are made per transaction, and if the 7th attempt does not succeed the transaction ends in fail.
- R3: An outcome of kind 0 (channel ok) with reply code 0 (ACK) ends in pass for a write, and also for a read whose `bytesBack` equals `reqLen`. A shorter read retries after 300 us and ends in fail once 7 short reads have been counted.
- R4: Reply code 2 (native defer) adds one to the defer count and adds `pollPeriodMs` to the accumulated defer time. Codes 2 and 4 (I2C-side defer) both set a sticky defer-seen flag, and both retry after `deferDelayMs` milliseconds, with that delay also added to the defer time. Code 3 (I2C-side NACK) retries with no pause. With any of the codes 2, 3 or 4, the transaction fails if the defer count is at least 7 and the defer time is at least 50 ms.
- R5: Reply code 5 (I2C busy defer) clears the native defer count, retries with no pause, and ends in fail once 7 of them have been counted.
- R6: The following end in fail at once: reply code 1 (native NACK), reply code 6 (disconnect reply), any reply code above 6, kind 3 (disconnect), kind 4 (engine acquire error), and kinds 5 to 7 (unknown).
- R7: Kind 1 (invalid reply) retries after 400 us. The 2nd invalid reply counted ends in fail.
- R8: Kind 2 (timeout) with the defer-seen flag clear retries with no pause. The 3rd such timeout counted ends in fail.
- R9: Kind 2 with the defer-seen flag set adds one to the defer count, ends in fail when that count reaches 7, and otherwise retries after `deferDelayMs` milliseconds, or at once when that value is zero.
- R10: An outcome of kind 0 clears the timeout and invalid-reply counts. Outcomes of other kinds leave them as they are.
- R11: A new `txnStart` clears every count, the defer time and the defer-seen flag.
- R12: When the transaction finishes, `done` rises with exactly one of `pass` or `fail`. All three hold until `doneAck`, and `busy` is high only while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | Start a transaction (accepted only in idle) |
| isWrite | input | 1 | Transaction is a write |
| reqLen | input | LEN_W | Requested read length in bytes |
| deferDelayMs | input | DELAY_W | Pause after a defer, in ms |
| pollPeriodMs | input | DELAY_W | Polling timeout period charged per native defer, in ms |
| usTick | input | 1 | One-microsecond time base strobe |
| outcomeValid | input | 1 | Engine reports the result of the current attempt |
| outcomeKind | input | 3 | 0 ok, 1 invalid, 2 timeout, 3 disconnect, 4 acquire error, other unknown |
| replyCode | input | 4 | Reply code when the kind is 0 |
| bytesBack | input | LEN_W | Data bytes returned by a read |
| doneAck | input | 1 | Host acknowledges the verdict |
| attemptGo | output | 1 | Launch one attempt |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Verdict available |
| pass | output | 1 | Transaction succeeded |
| fail | output | 1 | Transaction failed |

## Verification
The bound checker watches, on every cycle, that attempt pulses last a single cycle, that no more than seven of them come in one transaction, that the verdict is exactly one of pass or fail and stays until it is acknowledged, and that a disconnect or acquire error ends the transaction on the next edge. Which counter a given outcome charges, that a successful outcome clears the timeout and invalid-reply counts, that a timeout is reclassified after a defer, and how long each pause lasts can only be shown by the bench's outcome sequences. For these the bench counts attempts and measures the gap from a reported outcome to the next launch.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  localparam logic [2:0] KIND_OK       = 3'd0;
  localparam logic [2:0] KIND_INVALID  = 3'd1;
  localparam logic [2:0] KIND_TIMEOUT  = 3'd2;

  localparam logic [3:0] REP_ACK      = 4'd0;
  localparam logic [3:0] REP_DEFER    = 4'd2;
  localparam logic [3:0] REP_SB_NACK  = 4'd3;
  localparam logic [3:0] REP_SB_DEFER = 4'd4;
  localparam logic [3:0] REP_SB_BUSY  = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_AWAIT, ST_PAUSE, ST_DONE
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic launch;
    logic commit;
    logic tickDown;
  } ctrl_strobe_t;

  // decision returned by the datapath for the outcome on the inputs
  typedef struct packed {
    logic finish;
    logic success;
    logic needWait;
  } verdict_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/aux_retry_dp.sv
module aux_retry_dp
  import aux_retry_pkg::*;
#(
  parameter int LEN_W          = 5,
  parameter int DELAY_W        = 8,
  parameter int TIME_W         = 10,
  parameter int MAX_ATTEMPTS   = 7,
  parameter int ACK_LIMIT      = 7,
  parameter int DEFER_LIMIT    = 7,
  parameter int BUSY_LIMIT     = 7,
  parameter int INVALID_LIMIT  = 2,
  parameter int TIMEOUT_LIMIT  = 3,
  parameter int DEFER_TIME_MS  = 50,
  parameter int SHORT_WAIT_US  = 300,
  parameter int INVALID_WAIT_US = 400,
  parameter int US_PER_MS      = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       ctrl,
  input  logic               isWrite,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [DELAY_W-1:0] deferDelayMs,
  input  logic [DELAY_W-1:0] pollPeriodMs,
  input  logic [2:0]         outcomeKind,
  input  logic [3:0]         replyCode,
  input  logic [LEN_W-1:0]   bytesBack,
  output verdict_t           verdict,
  output logic               timerZero
);

  localparam int LIM_MAX = maxOf(maxOf(maxOf(MAX_ATTEMPTS, ACK_LIMIT), maxOf(DEFER_LIMIT, BUSY_LIMIT)),
                                 maxOf(INVALID_LIMIT, TIMEOUT_LIMIT));
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam int WAIT_MAX = maxOf((2**DELAY_W - 1) * US_PER_MS, maxOf(SHORT_WAIT_US, INVALID_WAIT_US));
  localparam int WAIT_W  = $clog2(WAIT_MAX + 1);

  logic [CNT_W-1:0]  attemptCnt, ackCnt, deferCnt, busyCnt, invCnt, toCnt;
  logic [CNT_W-1:0]  ackN, deferN, busyN, invN, toN;
  logic [TIME_W-1:0] deferTime, deferTimeN;
  logic              deferSeen, deferSeenN;
  logic [WAIT_W-1:0] timer, waitLen, msWait;
  logic              fin, ok, fullRead;

  function automatic logic [TIME_W-1:0] satAdd(input logic [TIME_W-1:0] a,
                                               input logic [DELAY_W-1:0] b);
    logic [TIME_W:0] s;
    s = {1'b0, a} + (TIME_W+1)'(b);
    return s[TIME_W] ? '1 : s[TIME_W-1:0];
  endfunction

  assign fullRead = isWrite || (bytesBack == reqLen);
  assign msWait   = WAIT_W'(deferDelayMs) * WAIT_W'(US_PER_MS);

  always_comb begin
    ackN = ackCnt;  deferN = deferCnt;  busyN = busyCnt;
    invN = invCnt;  toN = toCnt;
    deferTimeN = deferTime;  deferSeenN = deferSeen;
    fin = 1'b0;  ok = 1'b0;  waitLen = '0;
    case (outcomeKind)
      KIND_OK: begin
        toN  = '0;
        invN = '0;
        case (replyCode)
          REP_ACK: begin
            if (fullRead) begin
              fin = 1'b1;
              ok  = 1'b1;
            end else begin
              ackN = ackCnt + 1'b1;
              if (ackN >= CNT_W'(ACK_LIMIT)) fin = 1'b1;
              else waitLen = WAIT_W'(SHORT_WAIT_US);
            end
          end
          REP_DEFER, REP_SB_DEFER, REP_SB_NACK: begin
            if (replyCode == REP_DEFER) begin
              deferN     = deferCnt + 1'b1;
              deferTimeN = satAdd(deferTime, pollPeriodMs);
            end
            if (replyCode != REP_SB_NACK) deferSeenN = 1'b1;
            if (deferN >= CNT_W'(DEFER_LIMIT) && deferTimeN >= TIME_W'(DEFER_TIME_MS)) begin
              fin = 1'b1;
            end else if (replyCode != REP_SB_NACK) begin
              waitLen    = msWait;
              deferTimeN = satAdd(deferTimeN, deferDelayMs);
            end
          end
          REP_SB_BUSY: begin
            deferN = '0;
            busyN  = busyCnt + 1'b1;
            if (busyN >= CNT_W'(BUSY_LIMIT)) fin = 1'b1;
          end
          default: fin = 1'b1;
        endcase
      end
      KIND_INVALID: begin
        invN = invCnt + 1'b1;
        if (invN >= CNT_W'(INVALID_LIMIT)) fin = 1'b1;
        else waitLen = WAIT_W'(INVALID_WAIT_US);
      end
      KIND_TIMEOUT: begin
        if (deferSeen) begin
          deferN = deferCnt + 1'b1;
          if (deferN >= CNT_W'(DEFER_LIMIT)) fin = 1'b1;
          else waitLen = msWait;
        end else begin
          toN = toCnt + 1'b1;
          if (toN >= CNT_W'(TIMEOUT_LIMIT)) fin = 1'b1;
        end
      end
      default: fin = 1'b1;
    endcase
    if (!fin && attemptCnt >= CNT_W'(MAX_ATTEMPTS)) fin = 1'b1;
  end

  assign verdict.finish   = fin;
  assign verdict.success  = ok;
  assign verdict.needWait = (waitLen != '0);
  assign timerZero        = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      attemptCnt <= '0;  ackCnt <= '0;  deferCnt <= '0;  busyCnt <= '0;
      invCnt <= '0;  toCnt <= '0;  deferTime <= '0;  deferSeen <= 1'b0;
      timer <= '0;
    end else begin
      if (ctrl.launch) attemptCnt <= attemptCnt + 1'b1;
      if (ctrl.commit) begin
        ackCnt <= ackN;  deferCnt <= deferN;  busyCnt <= busyN;
        invCnt <= invN;  toCnt <= toN;
        deferTime <= deferTimeN;  deferSeen <= deferSeenN;
        timer <= fin ? '0 : waitLen;
      end else if (ctrl.tickDown && timer != '0) begin
        timer <= timer - 1'b1;
      end
    end
  end

endmodule

// File: rtl/aux_retry_fsm.sv
module aux_retry_fsm
  import aux_retry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         txnStart,
  input  logic         outcomeValid,
  input  logic         doneAck,
  input  logic         usTick,
  input  verdict_t     verdict,
  input  logic         timerZero,
  output ctrl_strobe_t ctrl,
  output logic         attemptGo,
  output logic         busy,
  output logic         done,
  output logic         pass,
  output logic         fail
);

  ctrl_state_e state, stateN;
  logic        passReg;

  always_comb begin
    ctrl.clearAll = (state == ST_IDLE) && txnStart;
    ctrl.launch   = (state == ST_LAUNCH);
    ctrl.commit   = (state == ST_AWAIT) && outcomeValid;
    ctrl.tickDown = (state == ST_PAUSE) && usTick;
  end

  always_comb begin
    stateN = state;
    case (state)
      ST_IDLE:   if (txnStart) stateN = ST_LAUNCH;
      ST_LAUNCH: stateN = ST_AWAIT;
      ST_AWAIT:  if (outcomeValid) begin
                   if (verdict.finish)        stateN = ST_DONE;
                   else if (verdict.needWait) stateN = ST_PAUSE;
                   else                       stateN = ST_LAUNCH;
                 end
      ST_PAUSE:  if (timerZero) stateN = ST_LAUNCH;
      ST_DONE:   if (doneAck) stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passReg <= 1'b0;
    end else begin
      state <= stateN;
      if (ctrl.commit && verdict.finish) passReg <= verdict.success;
    end
  end

  assign attemptGo = (state == ST_LAUNCH);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign pass      = done && passReg;
  assign fail      = done && !passReg;

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int LEN_W        = 5,
  parameter int DELAY_W      = 8,
  parameter int MAX_ATTEMPTS = 7,
  parameter int US_PER_MS    = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txnStart,
  input  logic               isWrite,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [DELAY_W-1:0] deferDelayMs,
  input  logic [DELAY_W-1:0] pollPeriodMs,
  input  logic               usTick,
  input  logic               outcomeValid,
  input  logic [2:0]         outcomeKind,
  input  logic [3:0]         replyCode,
  input  logic [LEN_W-1:0]   bytesBack,
  input  logic               doneAck,
  output logic               attemptGo,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               fail
);

  ctrl_strobe_t ctrl;
  verdict_t     verdict;
  logic         timerZero;

  aux_retry_fsm u_fsm (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .outcomeValid(outcomeValid),
    .doneAck(doneAck), .usTick(usTick), .verdict(verdict), .timerZero(timerZero),
    .ctrl(ctrl), .attemptGo(attemptGo), .busy(busy), .done(done),
    .pass(pass), .fail(fail)
  );

  aux_retry_dp #(
    .LEN_W(LEN_W), .DELAY_W(DELAY_W), .MAX_ATTEMPTS(MAX_ATTEMPTS), .US_PER_MS(US_PER_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .isWrite(isWrite), .reqLen(reqLen),
    .deferDelayMs(deferDelayMs), .pollPeriodMs(pollPeriodMs),
    .outcomeKind(outcomeKind), .replyCode(replyCode), .bytesBack(bytesBack),
    .verdict(verdict), .timerZero(timerZero)
  );

endmodule

// File: rtl/aux_retry_ctrl_chk.sv
module aux_retry_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 7
) (
  input logic       clk,
  input logic       rstN,
  input logic       txnStart,
  input logic       outcomeValid,
  input logic [2:0] outcomeKind,
  input logic       doneAck,
  input logic       attemptGo,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic       fail
);

  logic       pending;
  logic [7:0] goCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      goCount <= '0;
    end else begin
      if (attemptGo) pending <= 1'b1;
      else if (outcomeValid) pending <= 1'b0;
      if (txnStart && !busy && !done) goCount <= '0;
      else if (attemptGo) goCount <= goCount + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !attemptGo);

  p_go_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    attemptGo |=> !attemptGo);

  p_attempt_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    goCount <= 8'(MAX_ATTEMPTS));

  p_quick_fail_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && outcomeValid && (outcomeKind == 3'd3 || outcomeKind == 3'd4)) |=> (done && fail));

  p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fail));

  p_verdict_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done && !doneAck) |=> (done && $stable(pass)));

  p_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneAck) |=> !done);

endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk(clk), .rstN(rstN), .txnStart(txnStart), .outcomeValid(outcomeValid),
  .outcomeKind(outcomeKind), .doneAck(doneAck), .attemptGo(attemptGo),
  .busy(busy), .done(done), .pass(pass), .fail(fail)
);

// File: tb/aux_retry_ctrl_test.sv
module aux_retry_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txnStart = 1'b0;
  logic       isWrite = 1'b1;
  logic [4:0] reqLen = 5'd4;
  logic [7:0] deferDelayMs = 8'd0;
  logic [7:0] pollPeriodMs = 8'd10;
  logic       usTick = 1'b1;
  logic       outcomeValid = 1'b0;
  logic [2:0] outcomeKind = 3'd0;
  logic [3:0] replyCode = 4'd0;
  logic [4:0] bytesBack = 5'd0;
  logic       doneAck = 1'b0;
  logic       attemptGo, busy, done, pass, fail;

  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  aux_retry_ctrl uut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .isWrite(isWrite), .reqLen(reqLen),
    .deferDelayMs(deferDelayMs), .pollPeriodMs(pollPeriodMs), .usTick(usTick),
    .outcomeValid(outcomeValid), .outcomeKind(outcomeKind), .replyCode(replyCode),
    .bytesBack(bytesBack), .doneAck(doneAck), .attemptGo(attemptGo), .busy(busy),
    .done(done), .pass(pass), .fail(fail)
  );

  // outcome byte: {kind[2:0], reply[3:0], shortRead}
  localparam logic [7:0] O_ACK   = {3'd0, 4'd0, 1'b0};
  localparam logic [7:0] O_SHORT = {3'd0, 4'd0, 1'b1};
  localparam logic [7:0] O_NACK  = {3'd0, 4'd1, 1'b0};
  localparam logic [7:0] O_DEF   = {3'd0, 4'd2, 1'b0};
  localparam logic [7:0] O_SBN   = {3'd0, 4'd3, 1'b0};
  localparam logic [7:0] O_SBD   = {3'd0, 4'd4, 1'b0};
  localparam logic [7:0] O_BUSY  = {3'd0, 4'd5, 1'b0};
  localparam logic [7:0] O_RDISC = {3'd0, 4'd6, 1'b0};
  localparam logic [7:0] O_RUNK  = {3'd0, 4'd9, 1'b0};
  localparam logic [7:0] O_INV   = {3'd1, 4'd0, 1'b0};
  localparam logic [7:0] O_TO    = {3'd2, 4'd0, 1'b0};
  localparam logic [7:0] O_DISC  = {3'd3, 4'd0, 1'b0};
  localparam logic [7:0] O_ACQ   = {3'd4, 4'd0, 1'b0};
  localparam logic [7:0] O_UNK   = {3'd7, 4'd0, 1'b0};

  typedef struct packed {
    logic            wr;
    logic [0:6][7:0] outs;
    logic            expPass;
    logic [3:0]      expAtt;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, {O_ACK, {6{O_ACK}}}, 1'b1, 4'd1},                                 // R3 write ack
    '{1'b0, {O_ACK, {6{O_ACK}}}, 1'b1, 4'd1},                                 // R3 full read
    '{1'b0, {O_SHORT, O_ACK, {5{O_ACK}}}, 1'b1, 4'd2},                        // R3 short then full
    '{1'b0, {7{O_SHORT}}, 1'b0, 4'd7},                                        // R3 short limit
    '{1'b1, {O_NACK, {6{O_ACK}}}, 1'b0, 4'd1},                                // R6
    '{1'b1, {O_RDISC, {6{O_ACK}}}, 1'b0, 4'd1},                               // R6
    '{1'b1, {O_RUNK, {6{O_ACK}}}, 1'b0, 4'd1},                                // R6
    '{1'b1, {O_DISC, {6{O_ACK}}}, 1'b0, 4'd1},                                // R6
    '{1'b1, {O_ACQ, {6{O_ACK}}}, 1'b0, 4'd1},                                 // R6
    '{1'b1, {O_UNK, {6{O_ACK}}}, 1'b0, 4'd1},                                 // R6
    '{1'b1, {O_INV, O_INV, {5{O_ACK}}}, 1'b0, 4'd2},                          // R7
    '{1'b1, {O_INV, O_ACK, {5{O_ACK}}}, 1'b1, 4'd2},                          // R7
    '{1'b1, {O_DEF, O_TO, O_TO, O_TO, O_ACK, O_ACK, O_ACK}, 1'b1, 4'd5},      // R9
    '{1'b1, {O_TO, O_TO, O_TO, {4{O_ACK}}}, 1'b0, 4'd3},                      // R8 R11
    '{1'b1, {O_TO, O_TO, O_ACK, {4{O_ACK}}}, 1'b1, 4'd3},                     // R8
    '{1'b1, {O_TO, O_INV, O_TO, O_TO, {3{O_ACK}}}, 1'b0, 4'd4},               // R10
    '{1'b1, {O_TO, O_TO, O_SBN, O_TO, O_TO, O_ACK, O_ACK}, 1'b1, 4'd6},       // R10
    '{1'b1, {O_INV, O_DEF, O_INV, O_ACK, {3{O_ACK}}}, 1'b1, 4'd4},            // R10
    '{1'b1, {7{O_DEF}}, 1'b0, 4'd7},                                          // R2 R4
    '{1'b1, {{6{O_BUSY}}, O_ACK}, 1'b1, 4'd7},                                // R5
    '{1'b1, {7{O_BUSY}}, 1'b0, 4'd7},                                         // R5
    '{1'b1, {O_DEF, O_DEF, O_TO, O_TO, O_TO, O_TO, O_ACK}, 1'b1, 4'd7}        // R9 R2
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // runs one transaction; returns verdict, attempt count, gap before last launch
  task automatic runTxn(input logic wr, input logic [7:0] dly,
                        input logic [0:6][7:0] outs,
                        output logic gotPass, output logic gotFail,
                        output int att, output int lastGap);
    int sinceOut;
    logic [7:0] o;
    att = 0; sinceOut = 0; lastGap = 0;
    @(negedge clk);
    isWrite = wr; reqLen = 5'd4; deferDelayMs = dly; txnStart = 1'b1;
    @(negedge clk);
    txnStart = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (done) break;
      if (attemptGo) begin
        lastGap = sinceOut;
        att++;
        @(negedge clk);
        o = (att <= 7) ? outs[att-1] : O_ACK;
        outcomeKind  = o[7:5];
        replyCode    = o[4:1];
        bytesBack    = o[0] ? 5'd3 : 5'd4;
        outcomeValid = 1'b1;
        @(negedge clk);
        outcomeValid = 1'b0;
        sinceOut = 1;
      end else begin
        @(negedge clk);
        sinceOut++;
      end
    end
    gotPass = pass;
    gotFail = fail;
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
  endtask

  task automatic gapCase(input string req, input logic wr, input logic [7:0] dly,
                         input logic [0:6][7:0] outs, input int expGap);
    logic gp, gf;
    int at, gap;
    runTxn(wr, dly, outs, gp, gf, at, gap);
    if (expGap <= 1)
      check(gap == expGap, req, "gap to relaunch", gap, expGap);
    else
      check(gap >= expGap && gap <= expGap + 2, req, "gap to relaunch", gap, expGap);
    check(gp && !gf, req, "pass after pause", gp, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic gp, gf, held;
    int at, gap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !pass && !fail && !attemptGo, "R1", "idle outputs",
          {busy, done, pass, fail, attemptGo}, 0);

    foreach (VECS[i]) begin
      runTxn(VECS[i].wr, 8'd0, VECS[i].outs, gp, gf, at, gap);
      check(gp == VECS[i].expPass && gf == !VECS[i].expPass, "R2-R11 table",
            $sformatf("vector %0d verdict", i), gp, VECS[i].expPass);
      check(at == VECS[i].expAtt, "R2 attempts",
            $sformatf("vector %0d attempts", i), at, VECS[i].expAtt);
    end

    // R3 short read pauses 300 us
    gapCase("R3", 1'b0, 8'd0, {O_SHORT, O_ACK, {5{O_ACK}}}, 302);
    // R7 invalid reply pauses 400 us
    gapCase("R7", 1'b1, 8'd0, {O_INV, O_ACK, {5{O_ACK}}}, 402);
    // R4 native defer pauses deferDelayMs
    gapCase("R4", 1'b1, 8'd1, {O_DEF, O_ACK, {5{O_ACK}}}, 1002);
    // R4 I2C-side NACK relaunches at once
    gapCase("R4", 1'b1, 8'd1, {O_SBN, O_ACK, {5{O_ACK}}}, 1);
    // R9 timeout after defer pauses deferDelayMs
    gapCase("R9", 1'b1, 8'd1, {O_SBD, O_TO, O_ACK, {4{O_ACK}}}, 1002);
    // R9 timeout after defer with zero delay relaunches at once
    gapCase("R9", 1'b1, 8'd0, {O_DEF, O_TO, O_ACK, {4{O_ACK}}}, 1);
    // R8 plain timeout relaunches at once
    gapCase("R8", 1'b1, 8'd1, {O_TO, O_ACK, {5{O_ACK}}}, 1);

    // R12 verdict held until acknowledged
    @(negedge clk);
    isWrite = 1'b1; txnStart = 1'b1;
    @(negedge clk);
    txnStart = 1'b0;
    @(negedge clk);
    outcomeKind = 3'd3; replyCode = 4'd0; outcomeValid = 1'b1;
    @(negedge clk);
    outcomeValid = 1'b0;
    held = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (!(done && fail && !pass && !busy)) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R12", "verdict held", held, 1);
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
    check(!done && !fail && !busy, "R12", "released after ack", done, 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule